// File: doc/BRIEF.md
# Idle-Qualified Interconnect Clock Gate

This controller stops the two clocks of a shared interconnect, a double-rate clock and a single-rate clock derived from it by division by two, when software asks for it. It only closes the gate when three things are true together: the stop request is set, every monitored bus port is quiet, and an external fabric reports idle through its own handshake input. A port is quiet when none of its channel valid signals is high and its count of outstanding transactions is zero. The count rises on each address handshake and falls on each final response.

When any of these conditions goes away, the gate reopens on its own. This happens even if the request bit is still set. Bus interfaces outside the monitored ports are not observed, so software must quiesce them before it raises the request. The enable is held in a cell that is transparent only while the fast clock is low, so neither gated clock can produce a shortened pulse. Enable changes are applied only at single-rate boundaries, so both clocks stop and restart in phase.

Top module: `icx_clkgate`

## Requirements
- R1: While reset is active and right after it is released, `gated_o` is 0, the gated double-rate clock toggles with every fast-clock cycle, and the gated single-rate clock gives one rising edge per two fast cycles.
- R2: The clocks stop only after `stop_req_i`=1, `fab_idle_i`=1 and all ports quiet have held together for at least 2*QUAL_1X fast-clock cycles. Once those conditions are applied, `gated_o` is still 0 after the first fast edge and is 1 after the third.
- R3: A port is quiet only when its outstanding count is zero. `addr_acc_i` adds one to the count, `resp_done_i` subtracts one, and both in the same cycle leave it unchanged. A response at count zero is ignored, and the count does not go below zero.
- R4: A high bit of `chan_valid_i` on any port and any channel keeps the clocks running. Raising one while the clocks are stopped clears `gated_o` within two fast edges.
- R5: `fab_idle_i`=0 keeps the clocks running. Dropping it while the clocks are stopped clears `gated_o` within two fast edges.
- R6: `stop_req_i`=0 keeps the clocks running. Withdrawing it while the clocks are stopped clears `gated_o` within two fast edges.
- R7: After a wake, both gated clocks run at full rate for as long as any stop condition is missing.
- R8: Every rising edge of the gated single-rate clock coincides with a rising edge of the gated double-rate clock.
- R9: Every high phase of the gated double-rate clock lasts a full half fast period. Every high phase of the gated single-rate clock lasts one full fast period, and every low phase of it lasts at least one full fast period.
- R10: While `gated_o` is 1, neither gated clock produces a rising edge.
- R11: An idle window shorter than the qualification time, such as a single fast cycle of idle between busy cycles, never stops the clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_fast_i | input | 1 | Free-running double-rate source clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| stop_req_i | input | 1 | Software request to stop the interconnect clocks |
| fab_idle_i | input | 1 | External fabric idle flag, 1 = idle |
| chan_valid_i | input | NPORT*NCH | Per-port, per-channel valid indications |
| addr_acc_i | input | NPORT | Per-port address handshake pulse |
| resp_done_i | input | NPORT | Per-port final response handshake pulse |
| clk_2x_go | output | 1 | Gated double-rate clock |
| clk_1x_go | output | 1 | Gated single-rate clock (fast clock divided by two) |
| gated_o | output | 1 | 1 while the clocks are stopped |

## Verification
A wrong outstanding count appears at the ports as one of two failures. Either the clocks never stop after the last response, or they stop while a transaction is still open. Both are visible within six fast cycles of the triggering pulse. A wrong qualification counter, or a wrong boundary phase, shows up as `gated_o` rising on the first edge after idle begins, or as a one-cycle idle gap that stops the clocks. A missing wake shows up as `gated_o` still set two edges after activity returns. A faulty enable hold cell shows up as a high phase shorter than its nominal width, or as a single-rate edge without a matching double-rate edge, on the very first clock after the enable changes.

// File: rtl/icx_clkgate_pkg.sv
`timescale 1ns/1ps
package icx_clkgate_pkg;
   typedef enum logic {
      GATE_OPEN = 1'b0,
      GATE_SHUT = 1'b1
   } gate_mode_e;
endpackage

// File: rtl/icx_port_mon.sv
`timescale 1ns/1ps
module icx_port_mon #(
   parameter int NCH   = 5,
   parameter int CNT_W = 4
) (
   input  logic           clk_i,
   input  logic           rst_ni,
   input  logic [NCH-1:0] valid_i,
   input  logic           acc_i,
   input  logic           done_i,
   output logic           quiet_o
);
   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   logic [CNT_W-1:0] pend_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         pend_q <= '0;
      end else begin
         unique case ({acc_i, done_i})
            2'b10:   if (pend_q != CNT_MAX) pend_q <= pend_q + 1'b1;
            2'b01:   if (pend_q != '0)      pend_q <= pend_q - 1'b1;
            default: pend_q <= pend_q;
         endcase
      end
   end

   assign quiet_o = (valid_i == '0) && (pend_q == '0);
endmodule

// File: rtl/icx_idle_qual.sv
`timescale 1ns/1ps
module icx_idle_qual
   import icx_clkgate_pkg::*;
#(
   parameter int NPORT   = 2,
   parameter int QUAL_1X = 1
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             boundary_i,
   input  logic             req_i,
   input  logic             fab_idle_i,
   input  logic [NPORT-1:0] quiet_i,
   output logic             shut_o
);
   localparam int QUAL = 2 * QUAL_1X;
   localparam int HW   = (QUAL > 2) ? $clog2(QUAL) : 1;
   localparam logic [HW-1:0] HOLD_TOP = HW'(QUAL - 1);

   logic          all_idle;
   logic          idle_ok;
   logic [HW-1:0] hold_q;
   gate_mode_e    mode_q;

   assign all_idle = req_i && fab_idle_i && (&quiet_i);
   assign idle_ok  = all_idle && (hold_q == HOLD_TOP);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                hold_q <= '0;
      else if (!all_idle)         hold_q <= '0;
      else if (hold_q != HOLD_TOP) hold_q <= hold_q + 1'b1;
   end

   // Mode may only change on the fast edge that ends a single-rate cycle.
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)         mode_q <= GATE_OPEN;
      else if (boundary_i) mode_q <= idle_ok ? GATE_SHUT : GATE_OPEN;
   end

   assign shut_o = (mode_q == GATE_SHUT);
endmodule

// File: rtl/icx_gate_cell.sv
`timescale 1ns/1ps
module icx_gate_cell #(
   parameter bit LATCH_STYLE = 1'b1
) (
   input  logic clk_ref_i,
   input  logic en_i,
   input  logic src_i,
   output logic gclk_o
);
   logic en_hold;

   generate
      if (LATCH_STYLE) begin : g_latch
         always_latch begin
            if (!clk_ref_i) en_hold = en_i;
         end
      end else begin : g_negflop
         always_ff @(negedge clk_ref_i) en_hold <= en_i;
      end
   endgenerate

   assign gclk_o = src_i & en_hold;
endmodule

// File: rtl/icx_clkgate.sv
`timescale 1ns/1ps
module icx_clkgate #(
   parameter int NPORT       = 2,
   parameter int NCH         = 5,
   parameter int CNT_W       = 4,
   parameter int QUAL_1X     = 1,
   parameter bit LATCH_STYLE = 1'b1
) (
   input  logic                      clk_fast_i,
   input  logic                      rst_ni,
   input  logic                      stop_req_i,
   input  logic                      fab_idle_i,
   input  logic [NPORT-1:0][NCH-1:0] chan_valid_i,
   input  logic [NPORT-1:0]          addr_acc_i,
   input  logic [NPORT-1:0]          resp_done_i,
   output logic                      clk_2x_go,
   output logic                      clk_1x_go,
   output logic                      gated_o
);
   initial begin
      assert (NPORT >= 1)   else $error("icx_clkgate: NPORT must be at least 1");
      assert (NCH >= 1)     else $error("icx_clkgate: NCH must be at least 1");
      assert (CNT_W >= 1)   else $error("icx_clkgate: CNT_W must be at least 1");
      assert (QUAL_1X >= 1) else $error("icx_clkgate: QUAL_1X must be at least 1");
   end

   logic             div_q;
   logic [NPORT-1:0] quiet;
   logic             shut;

   // Free single-rate clock; a high value before an edge marks a boundary.
   always_ff @(posedge clk_fast_i or negedge rst_ni) begin
      if (!rst_ni) div_q <= 1'b0;
      else         div_q <= ~div_q;
   end

   generate
      for (genvar p = 0; p < NPORT; p++) begin : g_port
         icx_port_mon #(.NCH(NCH), .CNT_W(CNT_W)) u_mon (
            .clk_i   (clk_fast_i),
            .rst_ni  (rst_ni),
            .valid_i (chan_valid_i[p]),
            .acc_i   (addr_acc_i[p]),
            .done_i  (resp_done_i[p]),
            .quiet_o (quiet[p])
         );
      end
   endgenerate

   icx_idle_qual #(.NPORT(NPORT), .QUAL_1X(QUAL_1X)) u_qual (
      .clk_i      (clk_fast_i),
      .rst_ni     (rst_ni),
      .boundary_i (div_q),
      .req_i      (stop_req_i),
      .fab_idle_i (fab_idle_i),
      .quiet_i    (quiet),
      .shut_o     (shut)
   );

   icx_gate_cell #(.LATCH_STYLE(LATCH_STYLE)) u_gate_2x (
      .clk_ref_i (clk_fast_i),
      .en_i      (~shut),
      .src_i     (clk_fast_i),
      .gclk_o    (clk_2x_go)
   );

   icx_gate_cell #(.LATCH_STYLE(LATCH_STYLE)) u_gate_1x (
      .clk_ref_i (clk_fast_i),
      .en_i      (~shut),
      .src_i     (div_q),
      .gclk_o    (clk_1x_go)
   );

   assign gated_o = shut;
endmodule

// File: rtl/icx_clkgate_chk.sv
`timescale 1ns/1ps
module icx_clkgate_chk #(
   parameter int NPORT = 2,
   parameter int NCH   = 5
) (
   input logic                      clk_fast_i,
   input logic                      rst_ni,
   input logic                      stop_req_i,
   input logic                      fab_idle_i,
   input logic [NPORT-1:0][NCH-1:0] chan_valid_i,
   input logic                      clk_1x_go,
   input logic                      gated_o
);
   logic idle_in;
   assign idle_in = stop_req_i && fab_idle_i && (chan_valid_i == '0);

   p_gate_needs_idle_r2: assert property (@(posedge clk_fast_i) disable iff (!rst_ni)
      $rose(gated_o) |-> ($past(idle_in, 1) && $past(idle_in, 2)))
      else $error("r2: gate closed without a qualified idle window");

   p_wake_on_valid_r4: assert property (@(posedge clk_fast_i) disable iff (!rst_ni)
      (gated_o && (chan_valid_i != '0)) |-> ##2 !gated_o)
      else $error("r4: channel activity did not wake the clocks");

   p_wake_on_fabric_r5: assert property (@(posedge clk_fast_i) disable iff (!rst_ni)
      (gated_o && !fab_idle_i) |-> ##2 !gated_o)
      else $error("r5: fabric activity did not wake the clocks");

   p_wake_on_release_r6: assert property (@(posedge clk_fast_i) disable iff (!rst_ni)
      (gated_o && !stop_req_i) |-> ##2 !gated_o)
      else $error("r6: withdrawn request did not wake the clocks");

   p_quiet_1x_r10: assert property (@(posedge clk_fast_i) disable iff (!rst_ni)
      gated_o |-> !clk_1x_go)
      else $error("r10: single-rate clock high while gated");
endmodule

bind icx_clkgate icx_clkgate_chk #(.NPORT(NPORT), .NCH(NCH)) u_chk (
   .clk_fast_i   (clk_fast_i),
   .rst_ni       (rst_ni),
   .stop_req_i   (stop_req_i),
   .fab_idle_i   (fab_idle_i),
   .chan_valid_i (chan_valid_i),
   .clk_1x_go    (clk_1x_go),
   .gated_o      (gated_o)
);

// File: tb/icx_clkgate_tb_top.sv
`timescale 1ns/1ps
module icx_clkgate_tb_top;
   localparam int NP = 2;
   localparam int NC = 5;

   logic                clk = 1'b0;
   logic                rst_n = 1'b0;
   logic                req = 1'b0;
   logic                fab = 1'b0;
   logic [NP-1:0][NC-1:0] vld = '0;
   logic [NP-1:0]       acc = '0;
   logic [NP-1:0]       done = '0;
   logic                g2x, g1x, gated;

   int  checks = 0;
   int  errors = 0;
   bit  mon_on = 1'b0;
   bit  finished = 1'b0;
   longint n2x = 0, n1x = 0;
   realtime r2 = 0.0, r1 = 0.0, f1 = 0.0;
   bit  have_r2 = 1'b0, have_r1 = 1'b0, have_f1 = 1'b0;

   always #2 clk = ~clk;   // 250 MHz

   icx_clkgate #(.NPORT(NP), .NCH(NC)) dut_i (
      .clk_fast_i   (clk),
      .rst_ni       (rst_n),
      .stop_req_i   (req),
      .fab_idle_i   (fab),
      .chan_valid_i (vld),
      .addr_acc_i   (acc),
      .resp_done_i  (done),
      .clk_2x_go    (g2x),
      .clk_1x_go    (g1x),
      .gated_o      (gated)
   );

   task automatic chk(input string tag, input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic edges(input string tag, input longint e2, input longint e1);
      longint s2, s1;
      s2 = n2x; s1 = n1x;
      tick(8);
      chk({tag, " 2x edges"}, n2x - s2, e2);
      chk({tag, " 1x edges"}, n1x - s1, e1);
   endtask

   // R9: pulse widths; R8: phase alignment
   always @(posedge g2x) begin n2x++; r2 = $realtime; have_r2 = 1'b1; end
   always @(negedge g2x)
      if (mon_on && have_r2) chk("R9 2x high ps", $rtoi(($realtime - r2) * 1000.0 + 0.5), 2000);
   always @(negedge g1x) begin
      if (mon_on && have_r1) chk("R9 1x high ps", $rtoi(($realtime - r1) * 1000.0 + 0.5), 4000);
      f1 = $realtime; have_f1 = 1'b1;
   end
   always @(posedge g1x) begin
      n1x++;
      if (mon_on && have_f1)
         chk("R9 1x low >= 4000ps", (($realtime - f1) * 1000.0 >= 3999.0) ? 1 : 0, 1);
      r1 = $realtime; have_r1 = 1'b1;
      if (mon_on) begin
         #0.1;
         chk("R8 1x edge aligned to 2x edge", (have_r2 && ($realtime - r2) < 0.2) ? 1 : 0, 1);
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         checks++; errors++;
         $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      // R1 reset state
      tick(3);
      chk("R1 gated in reset", gated, 0);
      tick(2);
      rst_n = 1'b1;
      tick(1);
      mon_on = 1'b1;
      chk("R1 gated after reset", gated, 0);
      edges("R1 after reset", 8, 4);

      // Sweep of request, fabric idle and one channel on each port (R2 R4 R5 R6 R10)
      for (int m = 0; m < 16; m++) begin
         req = m[0]; fab = m[1];
         vld = '0;
         vld[0][0] = m[2];
         vld[1][NC-1] = m[3];
         tick(6);
         chk($sformatf("R2 sweep %0d gated", m), gated, (m == 3) ? 1 : 0);
         if (m == 3) edges($sformatf("R10 sweep %0d", m), 0, 0);
         else        edges($sformatf("R7 sweep %0d", m), 8, 4);
      end

      // Every channel of every port wakes within two edges (R4)
      for (int p = 0; p < NP; p++) begin
         for (int c = 0; c < NC; c++) begin
            vld = '0; req = 1'b1; fab = 1'b1;
            tick(6);
            chk($sformatf("R2 idle before p%0d c%0d", p, c), gated, 1);
            vld[p][c] = 1'b1;
            tick(2);
            chk($sformatf("R4 wake p%0d c%0d", p, c), gated, 0);
            edges($sformatf("R7 run p%0d c%0d", p, c), 8, 4);
         end
      end

      // Gate latency (R2)
      vld = '0; req = 1'b0; fab = 1'b1;
      tick(6);
      req = 1'b1;
      tick(1);
      chk("R2 not gated after first edge", gated, 0);
      tick(2);
      chk("R2 gated by third edge", gated, 1);

      // Fabric wake (R5) and request withdrawal (R6)
      fab = 1'b0;
      tick(2);
      chk("R5 wake on fabric busy", gated, 0);
      fab = 1'b1;
      tick(6);
      chk("R2 regate after fabric", gated, 1);
      req = 1'b0;
      tick(2);
      chk("R6 wake on request release", gated, 0);
      edges("R7 run after release", 8, 4);

      // Short idle windows never gate (R11)
      req = 1'b1; fab = 1'b1; vld = '0; vld[0][1] = 1'b1;
      tick(6);
      for (int k = 0; k < 4; k++) begin
         vld[0][1] = 1'b0;
         tick(1);
         chk($sformatf("R11 one-cycle idle %0d", k), gated, 0);
         vld[0][1] = 1'b1;
         tick(1);
         chk($sformatf("R11 busy again %0d", k), gated, 0);
         tick(k);
         chk($sformatf("R11 settled %0d", k), gated, 0);
      end

      // Outstanding count (R3)
      vld = '0; vld[1][0] = 1'b1; acc[1] = 1'b1;
      tick(1);
      vld = '0; acc = '0;
      tick(6);
      chk("R3 open transaction holds clocks", gated, 0);
      acc[1] = 1'b1; done[1] = 1'b1;
      tick(1);
      acc = '0; done = '0;
      tick(6);
      chk("R3 simultaneous acc and done", gated, 0);
      done[1] = 1'b1;
      tick(1);
      done = '0;
      tick(6);
      chk("R3 last response allows gating", gated, 1);
      done[1] = 1'b1;
      tick(1);
      done = '0;
      tick(6);
      chk("R3 response at zero ignored", gated, 1);
      acc[0] = 1'b1;
      tick(1);
      acc = '0;
      tick(6);
      chk("R3 new transaction wakes", gated, 0);
      done[0] = 1'b1;
      tick(1);
      done = '0;
      tick(6);
      chk("R3 port 0 closed regates", gated, 1);
      edges("R10 gated after count", 0, 0);

      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule